// File: doc/BRIEF.md
# SPI Scan-Portal Bit-Banger

This block is an SPI target (mode 0, most significant bit first) that takes one 8-bit word per selection. It copies each complete word into a portal register. The portal register drives the control and data lines of a serial scan-network client directly.

The host software does all scan sequencing. Each scan clock phase is one SPI word: the host writes a pattern with the scan clock bit clear, then the same pattern with it set. As an example, writing 0x40 and then 0x44 makes one capture cycle.

When a word completes, the block samples the level on the network's serial return line. It sends that level back to the host during the next selection. The block generates no scan timing of its own.

All SPI pins are oversampled in the system clock domain. Edges of the serial clock are detected there, so the whole block runs on one clock.

Top module: `scan_portal_spi`

## Requirements
- R1: After reset the scan outputs are all low except `scan_rst_o`, which is high. The return byte of the first selection is 0x00.
- R2: MOSI is sampled on rising SCLK edges, most significant bit first. The completed word maps onto the outputs as follows: bit 7 `scan_in_o`, bit 6 `capture_en_o`, bit 5 `shift_en_o`, bit 4 `update_en_o`, bit 3 `select_o`, bit 2 `tck_o`, bit 1 `scan_rst_o`.
- R3: The scan outputs change only when the eighth bit of a selection is received. They hold their value while SS_n is high and during the first seven bits.
- R4: If SS_n rises before eight bits have been received, the outputs keep their previous value. The pending return bit is also unchanged.
- R5: The return byte has the ScanOut level in bit 0 and zeros in bits 7..1. The ScanOut level is the one sampled when the previous complete word was committed. MISO presents the return byte MSB first and changes only after falling SCLK edges.
- R6: Bits clocked in after the eighth bit of the same selection are ignored.
- R7: Two words that differ only in bit 2 make one scan clock cycle: `tck_o` goes low and then high, while the enables keep the same values. The word pair 0x00/0x04 clocks with no enable asserted.
- R8: Bit 0 of a written word has no effect on any output.
- R9: MISO is low while SS_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_ss_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| scan_out_i | input | 1 | Serial return from the scan network |
| scan_in_o | output | 1 | Serial data into the scan network |
| capture_en_o | output | 1 | Capture enable |
| shift_en_o | output | 1 | Shift enable |
| update_en_o | output | 1 | Update enable |
| select_o | output | 1 | Network select |
| tck_o | output | 1 | Scan clock |
| scan_rst_o | output | 1 | Network reset, active high |

## Verification
The hardest cases to reach from the ports are selections that do not carry exactly eight bits. The bench covers this in two ways.

First, the driver task takes an explicit bit count. It ends one selection after five bits and then checks that the outputs did not move. The next full word must then return the ScanOut level that was pending before the aborted selection.

Second, the driver clocks sixteen bits in a single selection. The outputs must show only the first byte.

The return path is checked by changing the ScanOut level only between selections. The bench predicts which commit captured that level.

// File: rtl/scan_portal_pkg.sv
package scan_portal_pkg;
  localparam int PORTAL_W = 8;

  // Bit positions inside the portal word
  localparam int B_SCAN_IN = 7;
  localparam int B_CAPTURE = 6;
  localparam int B_SHIFT   = 5;
  localparam int B_UPDATE  = 4;
  localparam int B_SELECT  = 3;
  localparam int B_TCK     = 2;
  localparam int B_RESET   = 1;
  localparam int B_RETURN  = 0;

  // Committed value after reset: only the network reset is asserted
  localparam logic [PORTAL_W-1:0] PORTAL_RESET = 8'h02;

  typedef struct packed {
    logic scan_in;
    logic capture_en;
    logic shift_en;
    logic update_en;
    logic select;
    logic tck;
    logic net_rst;
  } scan_ctl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int WORD_W = 8,
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              ss_n_s,
  input  logic              mosi_s,
  input  logic [WORD_W-1:0] ret_word,
  output logic              miso_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic              sclk_q, ss_n_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] rx_q, rx_n, tx_q, tx_n;
  logic              got_q, got_n, done_q, done_n;
  logic              sel, sel_start, rise, fall;

  assign sel       = !ss_n_s;
  assign sel_start = sel && ss_n_q;
  assign rise      = sclk_s && !sclk_q;
  assign fall      = !sclk_s && sclk_q;

  always_comb begin
    cnt_n  = cnt_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    got_n  = got_q;
    done_n = 1'b0;
    if (!sel) begin
      cnt_n = '0;
      got_n = 1'b0;
      tx_n  = '0;
    end else if (sel_start) begin
      cnt_n = '0;
      got_n = 1'b0;
      tx_n  = ret_word;
    end else begin
      if (rise && !got_q) begin
        rx_n = {rx_q[WORD_W-2:0], mosi_s};
        if (cnt_q == CNT_W'(WORD_W-1)) begin
          cnt_n  = '0;
          got_n  = 1'b1;
          done_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      if (fall) tx_n = {tx_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_n_q <= 1'b1;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      got_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      ss_n_q <= ss_n_s;
      cnt_q  <= cnt_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      got_q  <= got_n;
      done_q <= done_n;
    end
  end

  assign miso_o    = tx_q[WORD_W-1];
  assign done_o    = done_q;
  assign rx_word_o = rx_q;

  a_r5_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !sel_start && !fall) |=> $stable(miso_o));
  a_r6_one_word_per_select: assert property (@(posedge clk) disable iff (!rst_n)
    (got_q && sel) |=> !done_o);
  a_r9_idle_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt_q == '0 && !miso_o));
endmodule

// File: rtl/portal_reg.sv
module portal_reg #(
  parameter int                WORD_W  = 8,
  parameter logic [WORD_W-1:0] RST_VAL = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              scan_out_s,
  output logic [WORD_W-1:0] portal_o,
  output logic [WORD_W-1:0] ret_word_o
);
  logic [WORD_W-1:0] portal_q, portal_n;
  logic              so_q, so_n;

  always_comb begin
    portal_n = portal_q;
    so_n     = so_q;
    if (commit) begin
      portal_n = {wr_word[WORD_W-1:1], 1'b0};
      so_n     = scan_out_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      portal_q <= RST_VAL;
      so_q     <= 1'b0;
    end else begin
      portal_q <= portal_n;
      so_q     <= so_n;
    end
  end

  assign portal_o   = portal_q;
  assign ret_word_o = {{(WORD_W-1){1'b0}}, so_q};

  a_r3_hold_between_words: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(portal_o) && $stable(ret_word_o)));
endmodule

// File: rtl/scan_portal_spi.sv
module scan_portal_spi
  import scan_portal_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_ss_n,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic scan_out_i,
  output logic scan_in_o,
  output logic capture_en_o,
  output logic shift_en_o,
  output logic update_en_o,
  output logic select_o,
  output logic tck_o,
  output logic scan_rst_o
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0]    pins_s;
  logic                sclk_s, ss_n_s, mosi_s, so_s;
  logic                done;
  logic [PORTAL_W-1:0] rx_word, portal, ret_word;
  scan_ctl_t           ctl;

  spi_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_ss_n, spi_mosi, scan_out_i}),
    .q(pins_s)
  );
  assign {sclk_s, ss_n_s, mosi_s, so_s} = pins_s;

  spi_word_shifter #(.WORD_W(PORTAL_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .ss_n_s(ss_n_s), .mosi_s(mosi_s),
    .ret_word(ret_word),
    .miso_o(spi_miso), .done_o(done), .rx_word_o(rx_word)
  );

  portal_reg #(.WORD_W(PORTAL_W), .RST_VAL(PORTAL_RESET)) u_portal (
    .clk(clk), .rst_n(rst_n),
    .commit(done), .wr_word(rx_word), .scan_out_s(so_s),
    .portal_o(portal), .ret_word_o(ret_word)
  );

  assign ctl.scan_in    = portal[B_SCAN_IN];
  assign ctl.capture_en = portal[B_CAPTURE];
  assign ctl.shift_en   = portal[B_SHIFT];
  assign ctl.update_en  = portal[B_UPDATE];
  assign ctl.select     = portal[B_SELECT];
  assign ctl.tck        = portal[B_TCK];
  assign ctl.net_rst    = portal[B_RESET];

  assign scan_in_o    = ctl.scan_in;
  assign capture_en_o = ctl.capture_en;
  assign shift_en_o   = ctl.shift_en;
  assign update_en_o  = ctl.update_en;
  assign select_o     = ctl.select;
  assign tck_o        = ctl.tck;
  assign scan_rst_o   = ctl.net_rst;

  a_r4_commit_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ss_n_s);
  a_r3_outputs_need_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(ctl));
endmodule

// File: tb/sim_scan_portal_spi.sv
`timescale 1ns/1ps
module sim_scan_portal_spi;
  localparam real HALF_SCLK = 80.0;

  logic clk, rst_n, sclk, ss_n, mosi, miso, so;
  logic scan_in, cap, shf, upd, sel, tck, nrst;

  typedef struct {
    logic [6:0] outs;
    logic [7:0] ret;
    logic [7:0] got;
    bit         chk_ret;
    string      req;
  } item_t;

  item_t q_exp[$];
  event  xfer_done;
  int    n_chk = 0, n_fail = 0;
  logic [7:0] exp_port = 8'h02;
  logic       pend = 1'b0;

  scan_portal_spi u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_ss_n(ss_n),
    .spi_mosi(mosi), .spi_miso(miso), .scan_out_i(so),
    .scan_in_o(scan_in), .capture_en_o(cap), .shift_en_o(shf),
    .update_en_o(upd), .select_o(sel), .tck_o(tck), .scan_rst_o(nrst)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [6:0] outs_now();
    return {scan_in, cap, shf, upd, sel, tck, nrst};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  // Driver: one selection carrying nbits bits of w, MSB first
  task automatic xfer(input logic [15:0] w, input int nbits, input string req);
    item_t it;
    logic [7:0] r = '0;
    ss_n = 1'b0;
    #(HALF_SCLK);
    for (int i = 0; i < nbits; i++) begin
      mosi = w[15-i];
      #(HALF_SCLK);
      if (i < 8) r[7-i] = miso;
      sclk = 1'b1;
      #(HALF_SCLK);
      sclk = 1'b0;
    end
    #(HALF_SCLK);
    ss_n = 1'b1;
    mosi = 1'b0;
    it.got     = r;
    it.req     = req;
    it.chk_ret = (nbits >= 8);
    it.ret     = {7'b0, pend};
    if (nbits >= 8) begin
      exp_port = {w[15:9], 1'b0};
      pend     = so;
    end
    it.outs = exp_port[7:1];
    q_exp.push_back(it);
    -> xfer_done;
    #200;
  endtask

  task automatic wr(input logic [7:0] b, input string req);
    xfer({b, 8'h00}, 8, req);
  endtask

  // Monitor: compares the design's results against the queued expectations
  initial begin
    forever begin
      item_t it;
      @(xfer_done);
      #50;
      it = q_exp.pop_front();
      check(outs_now() == it.outs, it.req, "outputs", {1'b0, outs_now()}, {1'b0, it.outs});
      if (it.chk_ret) check(it.got == it.ret, it.req, "return byte", it.got, it.ret);
      check(miso == 1'b0, "R9", "miso idle", {7'b0, miso}, 8'h00);
    end
  end

  initial begin
    #(1000000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; ss_n = 1'b1; mosi = 1'b0; so = 1'b0;
    #101;
    rst_n = 1'b1;
    #100;
    // R1: reset state
    check(outs_now() == 7'b0000001, "R1", "reset outputs", {1'b0, outs_now()}, 8'h01);
    check(miso == 1'b0, "R9", "miso after reset", {7'b0, miso}, 8'h00);

    so = 1'b1;
    wr(8'h40, "R1 R2 R7 capture low");     // first return byte 0x00
    wr(8'h44, "R5 R7 capture high");       // returns 1 sampled at previous commit
    so = 1'b0;
    wr(8'h20, "R5 R7 shift low");
    wr(8'h24, "R7 shift high");
    wr(8'hA9, "R8 bit0 ignored");          // scan_in + shift + select, bit0 set
    wr(8'hAD, "R2 R8 tck high");
    so = 1'b1;
    wr(8'h10, "R2 update low");
    wr(8'h14, "R2 update high");
    // R4: aborted selection after five bits of 0xF0
    so = 1'b0;
    xfer(16'hF000, 5, "R4 abort keeps outputs");
    wr(8'h00, "R4 R5 return survives abort");
    wr(8'h04, "R7 nop clock");
    // R6: sixteen bits in one selection, only the first byte counts
    xfer(16'h30FF, 16, "R6 extra bits ignored");
    wr(8'h08, "R2 select only");
    wr(8'h02, "R2 network reset");
    wr(8'h80, "R3 R2 scan_in only");

    #500;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule